// File: doc/BRIEF.md
# Single-Target External Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and presents them to one hart through a single external-interrupt output. Each source latches a pending bit. A per-source enable word selects which pending bits can reach the hart. Software reads a claim word to take the next interrupt, services it, and writes the same ID back to re-arm that source. There are no programmable priorities and there is only one target. Every source behaves as priority one, and the threshold is fixed at zero.

The bus side is a 32-bit word register port. The read data and the error flag are combinational and valid while a request is held. State changes, including the side effects of a claim read, take place at the clock edge that ends the access. Source ID 0 is reserved. It can never pend, be enabled or be claimed, so a claim value of zero means that no interrupt is waiting.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the pending word, the enable word and all internal mask bits are zero, and irq_o is low.
- R2: A pending bit n (n ≥ 1) is set at the clock edge where src_i[n] is high and its mask bit is clear. It stays set after the source drops, until a claim clears it. Pending bit 0 never sets.
- R3: A word write to byte offset 0x2000 loads the enable word with bit 0 forced to zero. A read of that offset returns the stored word.
- R4: The pending word reads at offset 0x1000. A write there returns err_o high and leaves the pending word unchanged.
- R5: Offset 0x200000 always reads zero. Writes to it complete without error and have no effect.
- R6: The source-priority words at offsets 4·n for n = 1..31 read zero without error. Writes to them complete without error and have no effect.
- R7: A read of offset 0x200004 returns the lowest n with pending AND enable bit n set. The same access clears pending bit n and sets mask bit n. With no such n the read returns 0 and changes nothing.
- R8: While mask bit n is set, src_i[n] cannot set pending bit n.
- R9: A write of value n to offset 0x200004 clears mask bit n only if enable bit n is set. Values of 32 or more are ignored, and none of these writes report an error.
- R10: irq_o is high exactly when the registered pending AND enable word is nonzero.
- R11: An access to an undefined offset (offset 0 included) or to an address whose two low bits are nonzero returns err_o high and rdata_o zero, and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt source lines; bit 0 unused |
| req_i | input | 1 | Register access request, one access per cycle |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 24 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high |
| err_o | output | 1 | Access error, valid while req_i is high |
| irq_o | output | 1 | External interrupt request to the hart |

## Verification
A stuck or mis-updated mask bit shows up on the ports only at the next source pulse. Either the pending word fails to capture an armed source, or it captures a source that should still be masked. The bench therefore follows every completion with a source pulse and a pending read, one cycle apart. An error in the pending or enable state shows in the same cycle on irq_o, and at the next claim read as a wrong ID. The claim sweep walks every set bit of a pattern in order, so a bad priority encoder or a claim that does not clear its bit is visible within one access.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned OFF_PEND  = 32'h0000_1000;
  localparam int unsigned OFF_EN    = 32'h0000_2000;
  localparam int unsigned OFF_THR   = 32'h0020_0000;
  localparam int unsigned OFF_CLAIM = 32'h0020_0004;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/ext_irq_decode.sv
module ext_irq_decode
  import ext_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NUM_SRC = 32
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              err_o
);
  localparam int unsigned PRIO_END = NUM_SRC * 4;

  reg_sel_e hit;

  always_comb begin
    hit = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i >= ADDR_W'(4) && addr_i < ADDR_W'(PRIO_END)) hit = SEL_PRIO;
      else if (addr_i == ADDR_W'(OFF_PEND))  hit = SEL_PEND;
      else if (addr_i == ADDR_W'(OFF_EN))    hit = SEL_EN;
      else if (addr_i == ADDR_W'(OFF_THR))   hit = SEL_THR;
      else if (addr_i == ADDR_W'(OFF_CLAIM)) hit = SEL_CLAIM;
    end
  end

  always_comb begin
    sel_o = SEL_NONE;
    err_o = 1'b0;
    if (req_i) begin
      // pending word is read-only
      if (hit == SEL_NONE || (hit == SEL_PEND && we_i)) err_o = 1'b1;
      else sel_o = hit;
    end
  end

  // R11
  always_comb begin
    if (err_o) decode_err_chk: assert (sel_o == SEL_NONE);
  end
endmodule

// File: rtl/ext_irq_pick.sv
module ext_irq_pick #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cand_i,
  output logic               found_o,
  output logic [ID_W-1:0]    id_o,
  output logic [NUM_SRC-1:0] hot_o
);
  // scan downward so the lowest index is the last one written
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end

  always_comb begin
    hot_o = '0;
    if (found_o) hot_o[id_o] = 1'b1;
  end

  // R7
  claim_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hot_o) && ((hot_o & cand_i) == hot_o));
  // R7
  claim_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ((cand_i & (hot_o - 1'b1)) == '0));
endmodule

// File: rtl/ext_irq_gate.sv
module ext_irq_gate #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] claim_hot_i,
  input  logic               cmp_vld_i,
  input  logic [ID_W-1:0]    cmp_id_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] mask_q;

  // ID 0 is reserved: no state at all
  assign pend_q[0] = 1'b0;
  assign mask_q[0] = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    logic cmp_hit;
    assign cmp_hit = cmp_vld_i && (cmp_id_i == ID_W'(i)) && en_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        // claim wins over a same-cycle capture
        if (claim_hot_i[i])              pend_q[i] <= 1'b0;
        else if (src_i[i] && !mask_q[i]) pend_q[i] <= 1'b1;

        if (claim_hot_i[i]) mask_q[i] <= 1'b1;
        else if (cmp_hit)   mask_q[i] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  // R2
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~$past(claim_hot_i) & ~pend_q) == '0));
  // R8
  masked_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0));
  // R9
  unmask_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~mask_q & $past(mask_q) & ~$past(en_i)) == '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] pick_hot;
  logic [NUM_SRC-1:0] claim_hot;
  logic [ID_W-1:0]    pick_id;
  logic               pick_found;
  logic               claim_rd;
  logic               cmp_wr;
  logic               cmp_ok;

  ext_irq_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) i_decode (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .sel_o (sel),
    .err_o (err_o)
  );

  assign cand = pend & en_q;

  ext_irq_pick #(.NUM_SRC(NUM_SRC)) i_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cand_i (cand),
    .found_o(pick_found),
    .id_o   (pick_id),
    .hot_o  (pick_hot)
  );

  assign claim_rd  = (sel == SEL_CLAIM) && !we_i;
  assign cmp_wr    = (sel == SEL_CLAIM) && we_i;
  assign cmp_ok    = wdata_i < DATA_W'(NUM_SRC);
  assign claim_hot = claim_rd ? pick_hot : '0;

  ext_irq_gate #(.NUM_SRC(NUM_SRC)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .en_i       (en_q),
    .claim_hot_i(claim_hot),
    .cmp_vld_i  (cmp_wr && cmp_ok),
    .cmp_id_i   (wdata_i[ID_W-1:0]),
    .pend_o     (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (sel == SEL_EN && we_i) en_q <= wdata_i[NUM_SRC-1:0] & ~NUM_SRC'(1);
  end

  always_comb begin
    rdata_o = '0;
    if (!we_i) begin
      unique case (sel)
        SEL_PEND:  rdata_o = DATA_W'(pend);
        SEL_EN:    rdata_o = DATA_W'(en_q);
        SEL_CLAIM: rdata_o = pick_found ? DATA_W'(pick_id) : '0;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |cand;

  // R3
  en_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_q[0]);
  // R10
  claim_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_rd && rdata_o != '0) |-> irq_o);
  // R11
  err_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && err_o) |=> (en_q == $past(en_q)));
endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  localparam logic [23:0] A_PEND = 24'h001000, A_EN = 24'h002000,
                          A_THR = 24'h200000, A_CLM = 24'h200004;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [23:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    rd = rdata; er = err;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); src = v;
    @(negedge clk); src = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    acc(0, A_PEND, 0, rd, er); chk("R1 pend", rd, 0);
    acc(0, A_EN, 0, rd, er);   chk("R1 en", rd, 0);
    acc(0, A_CLM, 0, rd, er);  chk("R7 empty claim", rd, 0);

    // R3 enable sweep
    acc(1, A_EN, 32'hFFFF_FFFF, rd, er);
    acc(0, A_EN, 0, rd, er); chk("R3 all", rd, 32'hFFFF_FFFE);
    for (int k = 0; k < 32; k++) begin
      acc(1, A_EN, 32'h1 << k, rd, er); chk("R3 wr err", {31'b0, er}, 0);
      acc(0, A_EN, 0, rd, er); chk("R3 bit", rd, (k == 0) ? 32'h0 : (32'h1 << k));
    end

    // R5 threshold
    acc(1, A_THR, 32'h5, rd, er); chk("R5 wr err", {31'b0, er}, 0);
    acc(0, A_THR, 0, rd, er);     chk("R5 rd", rd, 0); chk("R5 rd err", {31'b0, er}, 0);

    // R6 priority words
    for (int n = 1; n < 32; n++) begin
      acc(1, 24'(n * 4), 32'h7, rd, er); chk("R6 wr err", {31'b0, er}, 0);
      acc(0, 24'(n * 4), 0, rd, er);
      chk("R6 rd", rd, 0); chk("R6 rd err", {31'b0, er}, 0);
    end

    // R11 undefined and misaligned
    acc(0, 24'h0, 0, rd, er);      chk("R11 off0 err", {31'b0, er}, 1);
    acc(0, 24'h1004, 0, rd, er);   chk("R11 1004 err", {31'b0, er}, 1); chk("R11 rdata", rd, 0);
    acc(0, 24'h200008, 0, rd, er); chk("R11 200008 err", {31'b0, er}, 1);
    acc(1, 24'h2001, 32'hFFFF, rd, er); chk("R11 mis err", {31'b0, er}, 1);
    acc(0, A_EN, 0, rd, er);       chk("R11 en kept", rd, 32'h8000_0000);

    // R2 latch with enable off
    acc(1, A_EN, 0, rd, er);
    pat = 32'hA5A5_A5A5;
    pulse(pat);
    acc(0, A_PEND, 0, rd, er); chk("R2 latch", rd, pat & ~32'h1);
    chk("R10 irq off", {31'b0, irq}, 0);

    // R4 pending read-only
    acc(1, A_PEND, 0, rd, er); chk("R4 wr err", {31'b0, er}, 1);
    acc(0, A_PEND, 0, rd, er); chk("R4 kept", rd, pat & ~32'h1);

    acc(1, A_EN, 32'hFFFF_FFFE, rd, er);
    chk("R10 irq on", {31'b0, irq}, 1);

    // R7 claim sweep in ascending order
    for (int k = 1; k < 32; k++) begin
      if (pat[k]) begin
        acc(0, A_CLM, 0, rd, er); chk("R7 claim id", rd, k);
        acc(0, A_PEND, 0, rd, er);
        chk("R7 pend cleared", rd, pat & ~32'h1 & ~((32'h2 << k) - 1));
      end
    end
    acc(0, A_CLM, 0, rd, er); chk("R7 none", rd, 0);
    chk("R10 irq drained", {31'b0, irq}, 0);

    // R8 masked sources stay quiet
    pulse(32'hFFFF_FFFF);
    acc(0, A_PEND, 0, rd, er); chk("R8 masked", rd, 32'h5A5A_5A5A);

    // R9 completion gated by enable
    acc(1, A_EN, 32'hFFFF_FFFA, rd, er);
    acc(1, A_CLM, 32'd2, rd, er); chk("R9 wr err", {31'b0, er}, 0);
    pulse(32'h4);
    acc(0, A_PEND, 0, rd, er); chk("R9 disabled", rd, 32'h5A5A_5A5A);
    acc(1, A_CLM, 32'd5, rd, er);
    pulse(32'h20);
    acc(0, A_PEND, 0, rd, er); chk("R9 rearmed", rd, 32'h5A5A_5A7A);
    acc(1, A_CLM, 32'd37, rd, er); chk("R9 range err", {31'b0, er}, 0);
    pulse(32'h80);
    acc(0, A_PEND, 0, rd, er); chk("R9 range ignored", rd, 32'h5A5A_5A7A);

    // R10 follows enable
    chk("R10 irq", {31'b0, irq}, 1);
    acc(1, A_EN, 0, rd, er); chk("R10 en off", {31'b0, irq}, 0);
    acc(1, A_EN, 32'hFFFF_FFFE, rd, er); chk("R10 en on", {31'b0, irq}, 1);
    acc(0, A_CLM, 0, rd, er); chk("R7 lowest", rd, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule